// File: doc/BRIEF.md
# Round-Robin Multi-Requester APB Switch

This block lets several APB requesters share one APB completer. Each requester raises its select, then raises its enable one clock later and holds both until it sees ready. The switch watches all requesters while it sits in an evaluation state. It picks one qualified requester by round-robin. It then runs a fresh setup phase and access phase toward the completer on behalf of that requester. When the completer answers, the response goes back to that requester alone.

Address, direction, write data, byte strobes, write-data parity and strobe parity all travel from the winner to the completer. Read data, read parity, ready and error travel back in the same cycle in which the completer gives ready. Parity is only passed through: the switch neither generates nor checks it. Two outputs let the surrounding logic follow the arbitration. One is a flag that is high while the switch is deciding. The other is a one-hot vector that marks the requester being served.

Top module: `apb_rr_switch`

## Requirements
- R1: While reset is asserted, and after it is released, the evaluation flag is 1, the grant vector is 0, completer select and enable are 0, and every requester ready is 0.
- R2: While no requester is qualified, the switch stays in evaluation with the grant vector 0 and completer select and enable held at 0.
- R3: A requester is qualified only when its enable is high and its select was already high at the previous clock edge. A select alone, or an enable without a select, never produces a grant.
- R4: After a grant, the completer sees exactly one cycle with select 1 and enable 0, followed by select 1 and enable 1.
- R5: The evaluation flag goes to 0 in the cycle the grant appears. It returns to 1, with the grant vector cleared, in the cycle after the access phase ends with completer ready high.
- R6: The grant vector has at most one bit set. Bit k set means requester k is being served.
- R7: While a requester is granted, the completer sees that requester's address, write flag, write data, write-data parity (one bit per byte), strobe (one bit per byte) and strobe-parity bit.
- R8: During a read (write flag 0), the strobe and strobe parity driven to the completer are all zero.
- R9: Completer ready, error, read data and read parity reach only the granted requester, in the same cycle as completer ready. All other requesters see ready 0, error 0 and zero read data.
- R10: A new grant goes to the first qualified requester found by counting upward, with wrap-around, from the requester after the one granted last. After reset the search starts at requester 0.
- R11: While the completer holds ready low in the access phase, completer select, enable and address stay steady, and no requester sees ready.
- R12: A write forwards the strobe unchanged. With strobe 4'b1001 on a 32-bit word, a strobe-honouring completer updates only byte lanes 3 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eval_o | output | 1 | High while the switch is choosing a requester |
| grant_o | output | NREQ | One-hot mark of the requester being served |
| req_sel_i | input | NREQ | Requester select, one per requester |
| req_en_i | input | NREQ | Requester enable, one per requester |
| req_write_i | input | NREQ | Requester write flag (1 = write) |
| req_addr_i | input | NREQ*AW | Requester addresses, requester k in slice k |
| req_wdata_i | input | NREQ*DW | Requester write data |
| req_wpar_i | input | NREQ*DW/8 | Requester write-data parity, one bit per byte |
| req_strb_i | input | NREQ*DW/8 | Requester byte strobes |
| req_spar_i | input | NREQ | Requester strobe parity bit |
| req_rdata_o | output | NREQ*DW | Read data returned to each requester |
| req_rpar_o | output | NREQ*DW/8 | Read parity returned to each requester |
| req_ready_o | output | NREQ | Ready returned to each requester |
| req_err_o | output | NREQ | Error returned to each requester |
| cpl_sel_o | output | 1 | Completer select |
| cpl_en_o | output | 1 | Completer enable |
| cpl_write_o | output | 1 | Completer write flag |
| cpl_addr_o | output | AW | Completer address |
| cpl_wdata_o | output | DW | Completer write data |
| cpl_wpar_o | output | DW/8 | Completer write-data parity |
| cpl_strb_o | output | DW/8 | Completer byte strobes |
| cpl_spar_o | output | 1 | Completer strobe parity |
| cpl_rdata_i | input | DW | Completer read data |
| cpl_rpar_i | input | DW/8 | Completer read parity |
| cpl_ready_i | input | 1 | Completer ready |
| cpl_err_i | input | 1 | Completer error |

## Verification
The assertions assume well-behaved requesters. Each one raises enable one clock after select, then holds select, enable, address and payload steady until it sees its own ready. They also assume the completer drives ready only during an access phase. The bench requesters follow that order, which is what makes the address-stability check during wait states valid. The bench completer gates ready with completer select and enable. For the simultaneous round-robin case, the bench drops each requester in the half cycle after its ready, before the next arbitration edge.

// File: rtl/apb_sw_pkg.sv
package apb_sw_pkg;

    typedef enum logic [1:0] {
        ST_EVAL   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } sw_state_e;

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] last_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o,
    output logic [N-1:0]  onehot_o
);

    logic [IW-1:0] cand;

    // Scan upward from the slot after the previous winner, wrapping at N.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        cand    = '0;
        for (int i = 0; i < N; i++) begin
            cand = IW'((int'(last_i) + 1 + i) % N);
            if (!found_o && req_i[cand]) begin
                found_o = 1'b1;
                idx_o   = cand;
            end
        end
    end

    assign onehot_o = found_o ? (N'(1) << idx_o) : '0;

    // R10: a chosen slot always carries a live request
    always_comb begin
        if (found_o) begin
            p_pick_live_r10: assert (req_i[idx_o]);
        end
    end

endmodule

// File: rtl/req_mux.sv
module req_mux #(
    parameter int N  = 4,
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int SB = DW / 8
) (
    input  logic [N-1:0]    grant_i,
    input  logic [N-1:0]    write_i,
    input  logic [N*AW-1:0] addr_i,
    input  logic [N*DW-1:0] wdata_i,
    input  logic [N*SB-1:0] wpar_i,
    input  logic [N*SB-1:0] strb_i,
    input  logic [N-1:0]    spar_i,
    output logic            write_o,
    output logic [AW-1:0]   addr_o,
    output logic [DW-1:0]   wdata_o,
    output logic [SB-1:0]   wpar_o,
    output logic [SB-1:0]   strb_o,
    output logic            spar_o
);

    // AND-OR select on a one-hot grant; an empty grant yields all zeros.
    always_comb begin
        write_o = 1'b0;
        addr_o  = '0;
        wdata_o = '0;
        wpar_o  = '0;
        strb_o  = '0;
        spar_o  = 1'b0;
        for (int k = 0; k < N; k++) begin
            write_o = write_o | (grant_i[k] & write_i[k]);
            addr_o  = addr_o  | ({AW{grant_i[k]}} & addr_i[k*AW +: AW]);
            wdata_o = wdata_o | ({DW{grant_i[k]}} & wdata_i[k*DW +: DW]);
            wpar_o  = wpar_o  | ({SB{grant_i[k]}} & wpar_i[k*SB +: SB]);
            strb_o  = strb_o  | ({SB{grant_i[k]}} & strb_i[k*SB +: SB]);
            spar_o  = spar_o  | (grant_i[k] & spar_i[k]);
        end
    end

endmodule

// File: rtl/rsp_demux.sv
module rsp_demux #(
    parameter int N  = 4,
    parameter int DW = 32,
    parameter int SB = DW / 8
) (
    input  logic [N-1:0]    grant_i,
    input  logic            active_i,
    input  logic            ready_i,
    input  logic            err_i,
    input  logic [DW-1:0]   rdata_i,
    input  logic [SB-1:0]   rpar_i,
    output logic [N-1:0]    ready_o,
    output logic [N-1:0]    err_o,
    output logic [N*DW-1:0] rdata_o,
    output logic [N*SB-1:0] rpar_o
);

    for (genvar k = 0; k < N; k++) begin : g_slot
        logic route;
        assign route                 = active_i & grant_i[k];
        assign ready_o[k]            = route & ready_i;
        assign err_o[k]              = route & ready_i & err_i;
        assign rdata_o[k*DW +: DW]   = route ? rdata_i : '0;
        assign rpar_o[k*SB +: SB]    = route ? rpar_i  : '0;
    end

endmodule

// File: rtl/apb_rr_switch.sv
module apb_rr_switch
    import apb_sw_pkg::*;
#(
    parameter int NREQ = 4,
    parameter int AW   = 16,
    parameter int DW   = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic                   eval_o,
    output logic [NREQ-1:0]        grant_o,
    input  logic [NREQ-1:0]        req_sel_i,
    input  logic [NREQ-1:0]        req_en_i,
    input  logic [NREQ-1:0]        req_write_i,
    input  logic [NREQ*AW-1:0]     req_addr_i,
    input  logic [NREQ*DW-1:0]     req_wdata_i,
    input  logic [NREQ*DW/8-1:0]   req_wpar_i,
    input  logic [NREQ*DW/8-1:0]   req_strb_i,
    input  logic [NREQ-1:0]        req_spar_i,
    output logic [NREQ*DW-1:0]     req_rdata_o,
    output logic [NREQ*DW/8-1:0]   req_rpar_o,
    output logic [NREQ-1:0]        req_ready_o,
    output logic [NREQ-1:0]        req_err_o,
    output logic                   cpl_sel_o,
    output logic                   cpl_en_o,
    output logic                   cpl_write_o,
    output logic [AW-1:0]          cpl_addr_o,
    output logic [DW-1:0]          cpl_wdata_o,
    output logic [DW/8-1:0]        cpl_wpar_o,
    output logic [DW/8-1:0]        cpl_strb_o,
    output logic                   cpl_spar_o,
    input  logic [DW-1:0]          cpl_rdata_i,
    input  logic [DW/8-1:0]        cpl_rpar_i,
    input  logic                   cpl_ready_i,
    input  logic                   cpl_err_i
);

    localparam int SB = DW / 8;
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

    typedef struct packed {
        sw_state_e       state;
        logic [NREQ-1:0] grant;
        logic [IW-1:0]   gidx;
        logic [IW-1:0]   last;
        logic [NREQ-1:0] seen;
    } regs_t;

    regs_t r_q, r_d;

    logic [NREQ-1:0] qual;
    logic            pick_found;
    logic [IW-1:0]   pick_idx;
    logic [NREQ-1:0] pick_oh;
    logic            mux_write;
    logic [SB-1:0]   mux_strb;
    logic            mux_spar;

    // A requester counts only once its enable follows a select seen at the last edge.
    assign qual = req_sel_i & req_en_i & r_q.seen;

    rr_pick #(.N(NREQ), .IW(IW)) u_pick (
        .req_i    (qual),
        .last_i   (r_q.last),
        .found_o  (pick_found),
        .idx_o    (pick_idx),
        .onehot_o (pick_oh)
    );

    always_comb begin
        r_d      = r_q;
        r_d.seen = req_sel_i;
        case (r_q.state)
            ST_EVAL: begin
                if (pick_found) begin
                    r_d.state = ST_SETUP;
                    r_d.grant = pick_oh;
                    r_d.gidx  = pick_idx;
                end
            end
            ST_SETUP: begin
                r_d.state = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (cpl_ready_i) begin
                    r_d.state = ST_EVAL;
                    r_d.grant = '0;
                    r_d.last  = r_q.gidx;
                end
            end
            default: begin
                r_d.state = ST_EVAL;
                r_d.grant = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_EVAL;
            r_q.grant <= '0;
            r_q.gidx  <= '0;
            r_q.last  <= IW'(NREQ - 1);
            r_q.seen  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign eval_o    = (r_q.state == ST_EVAL);
    assign grant_o   = r_q.grant;
    assign cpl_sel_o = (r_q.state != ST_EVAL);
    assign cpl_en_o  = (r_q.state == ST_ACCESS);

    req_mux #(.N(NREQ), .AW(AW), .DW(DW), .SB(SB)) u_mux (
        .grant_i (r_q.grant),
        .write_i (req_write_i),
        .addr_i  (req_addr_i),
        .wdata_i (req_wdata_i),
        .wpar_i  (req_wpar_i),
        .strb_i  (req_strb_i),
        .spar_i  (req_spar_i),
        .write_o (mux_write),
        .addr_o  (cpl_addr_o),
        .wdata_o (cpl_wdata_o),
        .wpar_o  (cpl_wpar_o),
        .strb_o  (mux_strb),
        .spar_o  (mux_spar)
    );

    assign cpl_write_o = mux_write;
    assign cpl_strb_o  = mux_strb & {SB{mux_write}};
    assign cpl_spar_o  = mux_spar & mux_write;

    rsp_demux #(.N(NREQ), .DW(DW), .SB(SB)) u_demux (
        .grant_i  (r_q.grant),
        .active_i (cpl_en_o),
        .ready_i  (cpl_ready_i),
        .err_i    (cpl_err_i),
        .rdata_i  (cpl_rdata_i),
        .rpar_i   (cpl_rpar_i),
        .ready_o  (req_ready_o),
        .err_o    (req_err_o),
        .rdata_o  (req_rdata_o),
        .rpar_o   (req_rpar_o)
    );

    // R6: never more than one requester marked
    p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R2: evaluation means the completer is idle and nobody is marked
    p_eval_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eval_o |-> (grant_o == '0) && !cpl_sel_o && !cpl_en_o);

    // R5: outside evaluation exactly one requester is marked
    p_serving_marked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_o |-> ($countones(grant_o) == 1));

    // R4: setup lasts one cycle and is followed by access
    p_setup_then_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_sel_o && !cpl_en_o) |=> (cpl_sel_o && cpl_en_o));

    // R11: a stalled access holds its control and address
    p_wait_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_en_o && !cpl_ready_i) |=> (cpl_sel_o && cpl_en_o && $stable(cpl_addr_o) && $stable(grant_o)));

    // R5: completion returns the switch to evaluation
    p_done_to_eval_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_en_o && cpl_ready_i) |=> (eval_o && grant_o == '0));

    // R8: reads carry no strobe
    p_read_nostrobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_sel_o && !cpl_write_o) |-> (cpl_strb_o == '0) && !cpl_spar_o);

    // R9: ready reaches only the marked requester, and only with completer ready in access
    p_ready_routed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready_o != '0) |-> (cpl_ready_i && cpl_en_o && ((req_ready_o & ~grant_o) == '0)));

    // R3: a new grant follows select-then-enable from that requester
    p_qualified_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpl_sel_o) |-> (((grant_o & $past(req_sel_i & req_en_i)) != '0)
                              && ((grant_o & $past(req_sel_i, 2)) != '0)));

endmodule

// File: tb/apb_rr_switch_bench.sv
`timescale 1ns/1ps
module apb_rr_switch_bench;

    localparam int N  = 4;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SB = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic                eval_o;
    logic [N-1:0]        grant_o;
    logic [N-1:0]        sel = '0, en = '0, wr = '0, spar = '0;
    logic [N*AW-1:0]     addr = '0;
    logic [N*DW-1:0]     wdata = '0;
    logic [N*SB-1:0]     wpar = '0, strb = '0;
    logic [N*DW-1:0]     rdata_o;
    logic [N*SB-1:0]     rpar_o;
    logic [N-1:0]        ready_o, err_o;
    logic                c_sel, c_en, c_write, c_spar;
    logic [AW-1:0]       c_addr;
    logic [DW-1:0]       c_wdata, c_rdata;
    logic [SB-1:0]       c_wpar, c_strb, c_rpar;
    logic                c_ready, c_err;
    logic                ready_en = 1'b1, err_en = 1'b0;
    logic [DW-1:0]       mem [4];

    int n_chk = 0;
    int n_bad = 0;

    apb_rr_switch #(.NREQ(N), .AW(AW), .DW(DW)) u_apb_rr_switch (
        .clk(clk), .rst_n(rst_n), .eval_o(eval_o), .grant_o(grant_o),
        .req_sel_i(sel), .req_en_i(en), .req_write_i(wr), .req_addr_i(addr),
        .req_wdata_i(wdata), .req_wpar_i(wpar), .req_strb_i(strb), .req_spar_i(spar),
        .req_rdata_o(rdata_o), .req_rpar_o(rpar_o), .req_ready_o(ready_o), .req_err_o(err_o),
        .cpl_sel_o(c_sel), .cpl_en_o(c_en), .cpl_write_o(c_write), .cpl_addr_o(c_addr),
        .cpl_wdata_o(c_wdata), .cpl_wpar_o(c_wpar), .cpl_strb_o(c_strb), .cpl_spar_o(c_spar),
        .cpl_rdata_i(c_rdata), .cpl_rpar_i(c_rpar), .cpl_ready_i(c_ready), .cpl_err_i(c_err)
    );

    function automatic logic [SB-1:0] par_of(logic [DW-1:0] d);
        logic [SB-1:0] p;
        for (int b = 0; b < SB; b++) p[b] = ^d[8*b +: 8];
        return p;
    endfunction

    // Completer model: strobe-honouring word store
    assign c_ready = ready_en & c_sel & c_en;
    assign c_err   = err_en & c_ready;
    assign c_rdata = mem[c_addr[3:2]];
    assign c_rpar  = par_of(c_rdata);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) mem[i] <= '0;
        end else if (c_ready && c_write && !c_err) begin
            for (int b = 0; b < SB; b++)
                if (c_strb[b]) mem[c_addr[3:2]][8*b +: 8] <= c_wdata[8*b +: 8];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1 chk(eval_o && grant_o == 0 && !c_sel && !c_en && ready_o == 0, "R1 in reset",
               {eval_o, grant_o, c_sel, c_en, ready_o}, {1'b1, 10'b0});
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(eval_o && grant_o == 0 && !c_sel && !c_en && ready_o == 0, "R1 after reset",
            {eval_o, grant_o, c_sel, c_en, ready_o}, {1'b1, 10'b0});
    endtask

    task automatic t_idle();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #1;
            chk(eval_o && grant_o == 0 && !c_sel && !c_en, "R2 idle",
                {eval_o, grant_o, c_sel, c_en}, {1'b1, 6'b0});
        end
    endtask

    task automatic t_qualify();
        @(negedge clk); sel[0] = 1'b1; en[1] = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk(eval_o && grant_o == 0 && !c_sel, "R3 unqualified", {eval_o, grant_o, c_sel}, {1'b1, 5'b0});
        end
        sel[0] = 1'b0; en[1] = 1'b0;
        @(negedge clk); #1;
        chk(eval_o && grant_o == 0, "R3 cleared", {eval_o, grant_o}, {1'b1, 4'b0});
    endtask

    task automatic xfer(input int k, input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [SB-1:0] st, input bit sp, input int nwait,
                        output logic [DW-1:0] rd, output bit er);
        ready_en = (nwait == 0);
        @(negedge clk);
        sel[k] = 1'b1; wr[k] = w; addr[k*AW +: AW] = a; wdata[k*DW +: DW] = d;
        wpar[k*SB +: SB] = ~par_of(d); strb[k*SB +: SB] = st; spar[k] = sp;
        @(negedge clk); en[k] = 1'b1;
        #1 chk(eval_o && grant_o == 0, "R3 enable not yet sampled", {eval_o, grant_o}, {1'b1, 4'b0});
        @(negedge clk); #1;
        chk(grant_o == (4'b1 << k), "R6 grant", grant_o, 4'b1 << k);
        chk(!eval_o, "R5 flag low on grant", eval_o, 0);
        chk(c_sel && !c_en, "R4 setup", {c_sel, c_en}, 2'b10);
        chk(c_addr == a && c_write == w, "R7 addr/write", {c_addr, c_write}, {a, w});
        if (w) chk(c_wdata == d && c_wpar == ~par_of(d) && c_strb == st && c_spar == sp,
                   "R7 payload", {c_wdata, c_wpar, c_strb, c_spar}, {d, ~par_of(d), st, sp});
        else   chk(c_strb == 0 && !c_spar, "R8 read strobe", {c_strb, c_spar}, 0);
        for (int i = 0; i < nwait; i++) begin
            @(negedge clk); #1;
            chk(c_sel && c_en && ready_o == 0 && c_addr == a, "R11 wait", {c_sel, c_en, ready_o, c_addr},
                {2'b11, 4'b0, a});
        end
        @(negedge clk); ready_en = 1'b1; #1;
        chk(c_sel && c_en, "R4 access", {c_sel, c_en}, 2'b11);
        chk(ready_o == (4'b1 << k), "R9 ready routed", ready_o, 4'b1 << k);
        rd = rdata_o[k*DW +: DW];
        er = err_o[k];
        chk(rpar_o[k*SB +: SB] == par_of(rd), "R9 read parity", rpar_o[k*SB +: SB], par_of(rd));
        chk(err_o == (err_en ? (4'b1 << k) : 4'b0), "R9 error routed", err_o, err_en ? (4'b1 << k) : 0);
        for (int j = 0; j < N; j++)
            if (j != k) chk(rdata_o[j*DW +: DW] == 0, "R9 other slot quiet", rdata_o[j*DW +: DW], 0);
        @(negedge clk); #1;
        chk(eval_o && grant_o == 0 && !c_sel, "R5 back to eval", {eval_o, grant_o, c_sel}, {1'b1, 5'b0});
        sel[k] = 1'b0; en[k] = 1'b0; wr[k] = 1'b0;
    endtask

    task automatic t_writes_reads();
        logic [DW-1:0] rd;
        bit er;
        xfer(2, 1'b1, 16'h0000, 32'h1122_3344, 4'b1111, 1'b0, 0, rd, er);
        xfer(0, 1'b1, 16'h0000, 32'hAABB_CCDD, 4'b1001, 1'b1, 0, rd, er);
        xfer(3, 1'b0, 16'h0000, 32'h0, 4'b1111, 1'b1, 2, rd, er);
        chk(rd == 32'hAA22_33DD, "R12 strobed lanes", rd, 32'hAA22_33DD);
        err_en = 1'b1;
        xfer(0, 1'b0, 16'h0004, 32'h0, 4'b0, 1'b0, 1, rd, er);
        chk(er, "R9 error seen", er, 1);
        err_en = 1'b0;
        xfer(1, 1'b1, 16'h0008, 32'h5A5A_0F0F, 4'b0110, 1'b0, 0, rd, er);
    endtask

    // Last winner is requester 1, so the order must be 2, 3, 0, 1.
    task automatic t_round_robin();
        int exp_order [4] = '{2, 3, 0, 1};
        int got = 0;
        int pend = -1;
        ready_en = 1'b1;
        @(negedge clk);
        for (int k = 0; k < N; k++) begin
            sel[k] = 1'b1; wr[k] = 1'b0; addr[k*AW +: AW] = AW'(k * 4);
        end
        @(negedge clk); en = '1;
        for (int c = 0; c < 40 && got < 4; c++) begin
            @(negedge clk);
            if (pend >= 0) begin sel[pend] = 1'b0; en[pend] = 1'b0; pend = -1; end
            #1;
            if (ready_o != 0) begin
                chk($onehot(ready_o), "R9 single ready", ready_o, 0);
                chk(ready_o == (4'b1 << exp_order[got]), "R10 order", ready_o, 4'b1 << exp_order[got]);
                for (int k = 0; k < N; k++) if (ready_o[k]) pend = k;
                got++;
            end
        end
        chk(got == 4, "R10 all served", got, 4);
        @(negedge clk);
        if (pend >= 0) begin sel[pend] = 1'b0; en[pend] = 1'b0; end
        sel = '0; en = '0;
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_qualify();
        t_writes_reads();
        t_round_robin();
        t_idle();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule